// File: doc/BRIEF.md
# CPU Hold Arbiter with Writeback Preemption

This block decides which secondary bus master owns the system bus while the CPU stands aside. There are three such masters: a DMA engine, an ISA-style master and a local-bus master. To take the bus from the CPU, the arbiter raises `hold_o`. Once `hlda_i` shows that the CPU has let go, it grants the bus to the highest-priority requester. A CPU with a write-back cache can take the bus back for a moment by pulling `wback_n_i` low. HOLD then drops at once, with no new arbitration. The current owner keeps its grant through the writeback, and the upper DMA address lines are floated if the DMA engine is the owner.

Two configuration registers are written through a small write port. One holds an arbitration lock that stops HOLD from rising while the CPU clock settles. The other holds the writeback timing mode and the enable for restart through CPU reset. A restart request waits until the CPU is in hold before a reset pulse goes out. When the ISA master releases the bus, a guard interval holds off both the CPU and the local master, because the bus signals recover slowly at that point.

Top module: `hold_arbiter`

## Requirements
- R1: After reset, `hold_o`, `gnt_o`, `cpu_rst_o` and `dma_hi_float_o` are all low. Both registers are zero, which means the short writeback mode is selected, the lock is off and restart through reset is disabled.
- R2: Requesters are ranked by index: bit 0 (DMA) first, then bit 1 (ISA), then bit 2 (local). A grant is issued only after `hlda_i` is seen high. At most one grant bit is high at any time.
- R3: The owner keeps its grant while its request stays high. When its request drops and no writeback is active, the grant clears. For a DMA or local owner, `hold_o` also falls.
- R4: A writeback request is a high-to-low change of `wback_n_i`, seen through a two-flop synchronizer. In short mode it drives `hold_o` low for exactly 4 cycles, while the grant is kept. `hold_o` then rises again, whatever the level of `wback_n_i`.
- R5: While the synchronized `wback_n_i` is low, the owner keeps its grant even if its request has been withdrawn. The grant is released only after `wback_n_i` returns high.
- R6: In legacy mode (register 0x0C bit 0 = 1), `hold_o` stays low for as long as `wback_n_i` stays low, and rises after it returns high.
- R7: `dma_hi_float_o` is high only while the DMA engine owns the bus and the synchronized writeback request is active. It is never high for any other owner.
- R8: While the lock bit (register 0x0B bit 0) is 1, `hold_o` never rises. If `hold_o` is already high when the lock is set, it stays high.
- R9: After the ISA master's request drops, `hold_o` stays high and no grant is issued until the synchronized `isa_own_n_i` has been high for at least 3 cycles.
- R10: With register 0x0C bit 3 = 1, a pulse on `restart_req_i` raises HOLD and then produces exactly one `cpu_rst_o` pulse after `hlda_i` is seen. While both the lock bit and bit 3 are 1, the reset stays pending. It issues once the lock is cleared.
- R11: A `restart_req_i` pulse that arrives while register 0x0C bit 3 is 0 has no effect: no HOLD and no `cpu_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_MASTERS | Bus requests (0 DMA, 1 ISA, 2 local) |
| gnt_o | output | NUM_MASTERS | One-hot bus grants |
| hold_o | output | 1 | Hold request to the CPU |
| hlda_i | input | 1 | Hold acknowledge from the CPU |
| wback_n_i | input | 1 | Asynchronous active-low writeback request |
| isa_own_n_i | input | 1 | Asynchronous active-low ISA master ownership line |
| restart_req_i | input | 1 | CPU restart request pulse |
| cpu_rst_o | output | 1 | One-cycle CPU reset pulse |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | REG_AW | Register address |
| cfg_wdata_i | input | REG_DW | Register write data |
| dma_hi_float_o | output | 1 | Float enable for the upper DMA address lines |

## Verification
Two conditions are the hardest to reach from the ports. The first is a writeback that arrives while the lock is set. The second is a pending reset held back by lock and reset-enable together. Both need several register writes, a live grant and an asynchronous input, all in a set order. Directed sequences build each condition step by step: write the registers, wait for the grant or for idle, assert the writeback or restart, then clear the lock and watch the HOLD edge or the reset pulse. Seeded random request mixes, including ISA ownership with its release guard, exercise the priority order and the release paths between those directed cases.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACQ,
      ST_GRANT,
      ST_WB,
      ST_GUARD
   } arb_state_e;

   // register addresses and bit positions seen by software
   localparam logic [7:0] LOCK_REG_ADDR = 8'h0B;
   localparam logic [7:0] CTRL_REG_ADDR = 8'h0C;
   localparam int         LOCK_BIT      = 0;
   localparam int         LEGACY_BIT    = 0;
   localparam int         RSTEN_BIT     = 3;
endpackage

// File: rtl/hold_arb_sync.sv
module hold_arb_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad
      $error("hold_arb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= {STAGES{RST_VAL}};
      else        shreg <= {shreg[STAGES-2:0], d};
   end

   assign q = shreg[STAGES-1];
endmodule

// File: rtl/hold_arb_regs.sv
module hold_arb_regs
   import hold_arb_pkg::*;
#(
   parameter int REG_AW = 8,
   parameter int REG_DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] addr,
   input  logic [REG_DW-1:0] wdata,
   output logic              lock_o,
   output logic              legacy_o,
   output logic              rsten_o
);
   if (REG_DW <= RSTEN_BIT) begin : g_bad_dw
      $error("hold_arb_regs: REG_DW too narrow for control bits");
   end
   if (REG_AW < 4) begin : g_bad_aw
      $error("hold_arb_regs: REG_AW too narrow for register map");
   end

   localparam logic [REG_AW-1:0] LOCK_A = REG_AW'(LOCK_REG_ADDR);
   localparam logic [REG_AW-1:0] CTRL_A = REG_AW'(CTRL_REG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_o   <= 1'b0;
         legacy_o <= 1'b0;
         rsten_o  <= 1'b0;
      end else if (we) begin
         if (addr == LOCK_A) lock_o <= wdata[LOCK_BIT];
         if (addr == CTRL_A) begin
            legacy_o <= wdata[LEGACY_BIT];
            rsten_o  <= wdata[RSTEN_BIT];
         end
      end
   end
endmodule

// File: rtl/hold_arb_prio.sv
module hold_arb_prio #(
   parameter int N = 3
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] pick,
   output logic         any
);
   // lowest index wins
   logic [N:0] seen;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign pick[i]   = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end
   assign any = seen[N];
endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter
   import hold_arb_pkg::*;
#(
   parameter int NUM_MASTERS  = 3,
   parameter int DMA_IDX      = 0,
   parameter int ISA_IDX      = 1,
   parameter int SYNC_STAGES  = 2,
   parameter int WB_SHORT_CYC = 4,
   parameter int GUARD_CYC    = 3,
   parameter int REG_AW       = 8,
   parameter int REG_DW       = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_MASTERS-1:0] req_i,
   output logic [NUM_MASTERS-1:0] gnt_o,
   output logic                   hold_o,
   input  logic                   hlda_i,
   input  logic                   wback_n_i,
   input  logic                   isa_own_n_i,
   input  logic                   restart_req_i,
   output logic                   cpu_rst_o,
   input  logic                   cfg_we_i,
   input  logic [REG_AW-1:0]      cfg_addr_i,
   input  logic [REG_DW-1:0]      cfg_wdata_i,
   output logic                   dma_hi_float_o
);
   localparam int WBW = $clog2(WB_SHORT_CYC + 1);
   localparam int GW  = $clog2(GUARD_CYC + 1);
   localparam logic [WBW-1:0] WB_LAST  = WBW'(WB_SHORT_CYC - 1);
   localparam logic [GW-1:0]  GUARD_TOP = GW'(GUARD_CYC);

   if (NUM_MASTERS < 2) begin : g_bad_n
      $error("hold_arbiter: need at least two masters");
   end
   if (DMA_IDX >= NUM_MASTERS || ISA_IDX >= NUM_MASTERS || DMA_IDX == ISA_IDX) begin : g_bad_idx
      $error("hold_arbiter: master indices out of range");
   end
   if (WB_SHORT_CYC < 1 || GUARD_CYC < 1) begin : g_bad_cyc
      $error("hold_arbiter: window lengths must be positive");
   end

   // configuration registers
   logic lock_q, legacy_q, rsten_q;

   hold_arb_regs #(.REG_AW(REG_AW), .REG_DW(REG_DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we_i),
      .addr     (cfg_addr_i),
      .wdata    (cfg_wdata_i),
      .lock_o   (lock_q),
      .legacy_o (legacy_q),
      .rsten_o  (rsten_q)
   );

   // asynchronous inputs
   logic wb_n_s, isa_n_s;

   hold_arb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_wb (
      .clk (clk), .rst_n (rst_n), .d (wback_n_i), .q (wb_n_s)
   );
   hold_arb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_isa (
      .clk (clk), .rst_n (rst_n), .d (isa_own_n_i), .q (isa_n_s)
   );

   logic wb_act, wb_act_d, wb_start;
   assign wb_act   = ~wb_n_s;
   assign wb_start = wb_act & ~wb_act_d;

   // release guard: counts cycles the ISA line has been seen released
   logic [GW-1:0] guard_cnt;
   logic          guard_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_act_d  <= 1'b0;
         guard_cnt <= '0;
      end else begin
         wb_act_d <= wb_act;
         if (!isa_n_s)                guard_cnt <= '0;
         else if (guard_cnt != GUARD_TOP) guard_cnt <= guard_cnt + 1'b1;
      end
   end
   assign guard_done = (guard_cnt == GUARD_TOP);

   // priority pick
   logic [NUM_MASTERS-1:0] pick;
   logic                   any_req;

   hold_arb_prio #(.N(NUM_MASTERS)) u_prio (
      .req  (req_i),
      .pick (pick),
      .any  (any_req)
   );

   // ownership state machine
   arb_state_e             state;
   logic                   hold_q;
   logic [NUM_MASTERS-1:0] gnt_q;
   logic [WBW-1:0]         wb_cnt;
   logic                   rst_pend, rst_pulse, rst_issue, rst_block;
   logic                   owner_req;

   assign rst_block = lock_q & rsten_q;
   assign owner_req = |(req_i & gnt_q);
   assign rst_issue = (state == ST_ACQ) && hlda_i && !any_req && rst_pend && !rst_block;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_pend  <= 1'b0;
         rst_pulse <= 1'b0;
      end else begin
         rst_pend  <= (rst_pend & ~rst_issue) | (restart_req_i & rsten_q);
         rst_pulse <= rst_issue;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         hold_q <= 1'b0;
         gnt_q  <= '0;
         wb_cnt <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if ((any_req || rst_pend) && !lock_q) begin
                  hold_q <= 1'b1;
                  state  <= ST_ACQ;
               end
            end
            ST_ACQ: begin
               if (hlda_i) begin
                  if (any_req) begin
                     gnt_q <= pick;
                     state <= ST_GRANT;
                  end else if (!rst_pend || !rst_block) begin
                     hold_q <= 1'b0;
                     state  <= ST_IDLE;
                  end
               end
            end
            ST_GRANT: begin
               if (wb_start) begin
                  hold_q <= 1'b0;
                  wb_cnt <= '0;
                  state  <= ST_WB;
               end else if (!owner_req && !wb_act) begin
                  gnt_q <= '0;
                  if (gnt_q[ISA_IDX]) begin
                     state <= ST_GUARD;
                  end else begin
                     hold_q <= 1'b0;
                     state  <= ST_IDLE;
                  end
               end
            end
            ST_WB: begin
               if (legacy_q) begin
                  if (!wb_act && !lock_q) begin
                     hold_q <= 1'b1;
                     state  <= ST_GRANT;
                  end
               end else if (wb_cnt == WB_LAST) begin
                  if (!lock_q) begin
                     hold_q <= 1'b1;
                     state  <= ST_GRANT;
                  end
               end else begin
                  wb_cnt <= wb_cnt + 1'b1;
               end
            end
            ST_GUARD: begin
               if (guard_done) begin
                  hold_q <= 1'b0;
                  state  <= ST_IDLE;
               end
            end
            default: begin
               state  <= ST_IDLE;
               hold_q <= 1'b0;
               gnt_q  <= '0;
            end
         endcase
      end
   end

   assign hold_o         = hold_q;
   assign gnt_o          = gnt_q;
   assign cpu_rst_o      = rst_pulse;
   assign dma_hi_float_o = gnt_q[DMA_IDX] & wb_act;
endmodule

// File: rtl/hold_arb_chk.sv
module hold_arb_chk #(
   parameter int NUM_MASTERS  = 3,
   parameter int DMA_IDX      = 0,
   parameter int WB_SHORT_CYC = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_MASTERS-1:0] gnt_o,
   input logic                   hold_o,
   input logic                   hlda_i,
   input logic                   cpu_rst_o,
   input logic                   dma_hi_float_o,
   input logic                   lock_q,
   input logic                   legacy_q
);
   localparam int LW = $clog2(WB_SHORT_CYC + 2);

   // length of the current hold-low stretch while a grant is kept
   logic [LW-1:0] low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 low_cnt <= '0;
      else if (!hold_o && |gnt_o) begin
         if (low_cnt != LW'(WB_SHORT_CYC + 1)) low_cnt <= low_cnt + 1'b1;
      end else                    low_cnt <= '0;
   end

   // R2
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));

   // R2
   grant_after_hlda_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt_o && !$past(|gnt_o)) |-> $past(hlda_i));

   // R5
   grant_kept_in_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt_o && !hold_o) |=> (gnt_o == $past(gnt_o)));

   // R8
   lock_blocks_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_o) |-> !$past(lock_q));

   // R4
   short_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hold_o) && |gnt_o && !legacy_q && !$past(legacy_q))
         |-> (low_cnt >= LW'(WB_SHORT_CYC)));

   // R7
   float_dma_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_hi_float_o |-> gnt_o[DMA_IDX]);

   // R10
   reset_after_hlda_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rst_o |-> ($past(hlda_i) && !$past(cpu_rst_o)));
endmodule

bind hold_arbiter hold_arb_chk #(
   .NUM_MASTERS  (NUM_MASTERS),
   .DMA_IDX      (DMA_IDX),
   .WB_SHORT_CYC (WB_SHORT_CYC)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .gnt_o          (gnt_o),
   .hold_o         (hold_o),
   .hlda_i         (hlda_i),
   .cpu_rst_o      (cpu_rst_o),
   .dma_hi_float_o (dma_hi_float_o),
   .lock_q         (lock_q),
   .legacy_q       (legacy_q)
);

// File: tb/test_hold_arbiter.sv
`timescale 1ns/1ps
module test_hold_arbiter;
   localparam int NM = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NM-1:0] req = '0;
   logic [NM-1:0] gnt;
   logic          hold, hlda;
   logic          wback_n = 1'b1;
   logic          isa_n = 1'b1;
   logic          restart = 1'b0;
   logic          cpu_rst;
   logic          we = 1'b0;
   logic [7:0]    addr = '0;
   logic [7:0]    wdata = '0;
   logic          flt;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   // CPU model: acknowledges hold one cycle later
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) hlda <= 1'b0;
      else        hlda <= hold;
   end

   hold_arbiter i_hold_arbiter (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_i          (req),
      .gnt_o          (gnt),
      .hold_o         (hold),
      .hlda_i         (hlda),
      .wback_n_i      (wback_n),
      .isa_own_n_i    (isa_n),
      .restart_req_i  (restart),
      .cpu_rst_o      (cpu_rst),
      .cfg_we_i       (we),
      .cfg_addr_i     (addr),
      .cfg_wdata_i    (wdata),
      .dma_hi_float_o (flt)
   );

   function automatic logic [NM-1:0] exp_pick(input logic [NM-1:0] r);
      for (int i = 0; i < NM; i++) if (r[i]) return NM'(1) << i;
      return '0;
   endfunction

   task automatic chk(input string rq, input string what, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic wait_hold(input logic v, input int maxc, output int n);
      n = 0;
      while (hold !== v && n < maxc) begin @(negedge clk); n++; end
   endtask

   task automatic wait_gnt(input int maxc);
      int n = 0;
      while (gnt == '0 && n < maxc) begin @(negedge clk); n++; end
   endtask

   task automatic count_rst(input int n, output int pulses);
      pulses = 0;
      for (int i = 0; i < n; i++) begin @(negedge clk); if (cpu_rst) pulses++; end
   endtask

   initial begin
      int n, lowcnt, p;
      logic [NM-1:0] r;
      logic          ok;
      void'($urandom(32'd20240611));
      cyc(4);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "hold", hold, 0);
      chk("R1", "gnt", gnt, 0);
      chk("R1", "cpu_rst", cpu_rst, 0);
      chk("R1", "float", flt, 0);

      // R2 / R3 random request mixes, R9 guard on ISA owners
      for (int it = 0; it < 40; it++) begin
         r = NM'($urandom % 8);
         if (r == '0) r = 3'b100;
         req = r;
         wait_gnt(40);
         chk("R2", "priority grant", gnt, exp_pick(r));
         chk("R2", "hold with grant", hold, 1);
         if (gnt[1]) isa_n = 1'b0;
         cyc(3 + ($urandom % 4));
         chk("R3", "grant kept while requested", gnt, exp_pick(r));
         ok = gnt[1];
         req = '0;
         isa_n = 1'b1;
         wait_hold(1'b0, 40, n);
         chk("R3", "released grant", gnt, 0);
         if (ok) chk("R9", "guard length", (n >= 3) ? 1 : 0, 1);
         cyc(2);
      end

      // R4 / R5 / R7 short writeback on a DMA owner
      req = 3'b001;
      wait_gnt(40);
      cyc(2);
      wback_n = 1'b0;
      wait_hold(1'b0, 20, n);
      chk("R7", "float during DMA writeback", flt, 1);
      lowcnt = 0;
      while (hold == 1'b0 && lowcnt < 20) begin
         chk("R5", "grant kept in window", gnt, 1);
         lowcnt++;
         @(negedge clk);
      end
      chk("R4", "short window length", lowcnt, 4);
      req = '0;
      cyc(8);
      chk("R5", "grant held while wback low", gnt, 1);
      chk("R4", "hold high after window", hold, 1);
      wback_n = 1'b1;
      cyc(6);
      chk("R5", "grant freed after wback high", gnt, 0);
      chk("R7", "float off after release", flt, 0);

      // R7 no float for ISA owner; R9 guard waits for ownership line
      req = 3'b010;
      wait_gnt(40);
      isa_n = 1'b0;
      cyc(3);
      wback_n = 1'b0;
      cyc(5);
      chk("R7", "no float for ISA owner", flt, 0);
      wback_n = 1'b1;
      cyc(8);
      req = '0;
      cyc(10);
      chk("R9", "hold held while ISA line low", hold, 1);
      chk("R9", "no grant during guard", gnt, 0);
      isa_n = 1'b1;
      wait_hold(1'b0, 30, n);
      chk("R9", "guard at least 3 cycles", (n >= 3) ? 1 : 0, 1);
      chk("R9", "hold falls after guard", hold, 0);

      // R6 legacy mode on local owner
      cfg(8'h0C, 8'h01);
      req = 3'b100;
      wait_gnt(40);
      cyc(2);
      wback_n = 1'b0;
      wait_hold(1'b0, 20, n);
      lowcnt = 0;
      for (int i = 0; i < 12; i++) begin @(negedge clk); if (!hold) lowcnt++; end
      chk("R6", "hold low while wback low", lowcnt, 12);
      wback_n = 1'b1;
      wait_hold(1'b1, 10, n);
      chk("R6", "hold back after wback high", hold, 1);
      chk("R6", "local owner kept", gnt, 4);
      req = '0;
      cyc(4);
      cfg(8'h0C, 8'h00);

      // R8 lock while idle
      cfg(8'h0B, 8'h01);
      req = 3'b001;
      lowcnt = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (hold || gnt != 0) lowcnt++; end
      chk("R8", "locked idle stays low", lowcnt, 0);
      cfg(8'h0B, 8'h00);
      wait_gnt(40);
      chk("R8", "grant after unlock", gnt, 1);

      // R8 lock while hold already high, then writeback under lock
      cfg(8'h0B, 8'h01);
      cyc(10);
      chk("R8", "hold high unaffected by lock", hold, 1);
      wback_n = 1'b0;
      wait_hold(1'b0, 20, n);
      cyc(12);
      chk("R8", "hold not re-raised under lock", hold, 0);
      wback_n = 1'b1;
      cyc(4);
      cfg(8'h0B, 8'h00);
      wait_hold(1'b1, 10, n);
      chk("R8", "hold rises after unlock", hold, 1);
      req = '0;
      wait_hold(1'b0, 20, n);

      // R10 restart through reset
      cfg(8'h0C, 8'h08);
      @(negedge clk); restart = 1'b1; @(negedge clk); restart = 1'b0;
      count_rst(20, p);
      chk("R10", "single reset pulse", p, 1);
      cfg(8'h0B, 8'h01);
      @(negedge clk); restart = 1'b1; @(negedge clk); restart = 1'b0;
      count_rst(30, p);
      chk("R10", "reset pending under lock", p, 0);
      chk("R10", "hold blocked under lock", hold, 0);
      cfg(8'h0B, 8'h00);
      count_rst(20, p);
      chk("R10", "pending reset issued after unlock", p, 1);

      // R11 restart ignored when disabled
      cfg(8'h0C, 8'h00);
      @(negedge clk); restart = 1'b1; @(negedge clk); restart = 1'b0;
      lowcnt = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (hold || cpu_rst) lowcnt++; end
      chk("R11", "disabled restart has no effect", lowcnt, 0);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule